// File: doc/BRIEF.md
# Punctured Convolutional Encoder with I/Q Bit Serializer

This block sits between a byte-wide interleaved data path and a pulse-shaping stage. It encodes each incoming byte with a rate-1/2 convolutional code of constraint length 7. It deletes coded bits according to the selected code rate. The surviving bits leave as one I/Q bit pair on every clock, so the clock runs at the symbol rate. The number of symbols a byte yields depends on the rate, so the block sets the pace of the byte path. It raises `byte_req`, and the upstream logic must present a byte on `data_in` during that cycle.

A byte is encoded as a whole when it is taken, and its surviving bits are appended to a short bit buffer. The buffer drains two bits per clock and asks for the next byte early enough that the symbol stream never stalls. A test mode skips the encoder and puncturing and sends the raw data bits out in pairs.

Top module: `conv_punct_ser`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it falls, `byte_req` is 1 and `i_bit`/`q_bit` are 0. Reset also clears the encoder history, sets the puncture position to 0 and sets the rate to 1/2.
- R2: At rate 1/2, each input bit u with history D1..D6 (D1 the newest) gives X = u^D1^D2^D3^D6 (generator 171 octal) and Y = u^D2^D3^D5^D6 (generator 133 octal). X goes out on `i_bit` and Y on `q_bit` in the same cycle.
- R3: `rate_sel` codes 1, 2, 3 and 4 select rates 2/3, 3/4, 5/6 and 7/8. The keep patterns below list positions 0,1,2,... of the puncture period:
  - rate 2/3: X keep 10, Y keep 11.
  - rate 3/4: X keep 101, Y keep 110.
  - rate 5/6: X keep 10101, Y keep 11010.
  - rate 7/8: X keep 1000101, Y keep 1111010.
  For each input bit, a kept X is emitted before a kept Y. The emitted stream is paired first bit on I and second on Q. The pairing and the puncture position both continue across byte boundaries.
- R4: `rate_sel` codes 5, 6 and 7 behave exactly like code 0 (rate 1/2).
- R5: When `uncoded_en` is 1 for a byte, its bits go out unencoded in pairs, the higher bit on I. The encoder history, puncture position and stored rate stay unchanged.
- R6: From the second cycle after reset, a valid pair is output on every clock with no gaps. The buffer never holds fewer than 2 or more than 18 bits. `byte_req` is high in exactly the cycles where fewer than 4 bits are buffered.
- R7: `data_in`, `rate_sel` and `uncoded_en` are sampled only at a rising edge where `byte_req` is 1. At other edges they have no effect on the output stream.
- R8: When a coded byte selects a different rate from the last coded byte, puncturing restarts at position 0. With the same rate, the position carries on.
- R9: Input bytes are consumed most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | DATA_W | Byte taken at an edge where byte_req is high |
| rate_sel | input | 3 | Code rate code, sampled with the byte |
| uncoded_en | input | 1 | Bypass encoding for this byte, sampled with the byte |
| byte_req | output | 1 | Next byte is taken at the coming edge |
| i_bit | output | 1 | I bit of the current symbol pair |
| q_bit | output | 1 | Q bit of the current symbol pair |

## Verification
Two functions can fall in the same edge: the buffer drains a pair, and a newly encoded byte is appended right behind the remaining bits. A rate or mode change can also restart the puncture position at that same edge. The bench provokes these cases by walking segments whose rate or mode differs from the one before. This puts a byte's tail bit and the next byte's head bit in one I/Q pair, and it makes rate changes arrive while the puncture position is mid-period. Each pair is judged against an independent bit-level model queue. The bench checks that the queue never runs dry and never grows beyond the buffer bound. While `byte_req` is low it drives junk on every sampled input.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_7_8 = 3'd4
  } rate_e;

  localparam int PUNCT_MAX = 7;
  localparam int PH_W      = $clog2(PUNCT_MAX);

  // Undefined codes fall back to the mother code.
  function automatic rate_e rate_decode(input logic [2:0] code);
    case (code)
      3'd1:    return RATE_2_3;
      3'd2:    return RATE_3_4;
      3'd3:    return RATE_5_6;
      3'd4:    return RATE_7_8;
      default: return RATE_1_2;
    endcase
  endfunction

  function automatic logic [PH_W-1:0] punct_period(input rate_e r);
    case (r)
      RATE_2_3: return PH_W'(2);
      RATE_3_4: return PH_W'(3);
      RATE_5_6: return PH_W'(5);
      RATE_7_8: return PH_W'(7);
      default:  return PH_W'(1);
    endcase
  endfunction

  // Bit p set: the X bit of period position p is transmitted.
  function automatic logic [PUNCT_MAX-1:0] keep_x(input rate_e r);
    case (r)
      RATE_2_3: return 7'b0000001;
      RATE_3_4: return 7'b0000101;
      RATE_5_6: return 7'b0010101;
      RATE_7_8: return 7'b1010001;
      default:  return 7'b0000001;
    endcase
  endfunction

  function automatic logic [PUNCT_MAX-1:0] keep_y(input rate_e r);
    case (r)
      RATE_2_3: return 7'b0000011;
      RATE_3_4: return 7'b0000011;
      RATE_5_6: return 7'b0001011;
      RATE_7_8: return 7'b0101111;
      default:  return 7'b0000001;
    endcase
  endfunction

endpackage

// File: rtl/cps_conv_coder.sv
module cps_conv_coder
  import cps_pkg::*;
#(
  parameter int             DATA_W = 8,
  parameter int             K      = 7,
  parameter logic [K-1:0]   GEN_X  = 7'o171,
  parameter logic [K-1:0]   GEN_Y  = 7'o133,
  localparam int            OUT_W  = 2 * DATA_W,
  localparam int            CNT_W  = $clog2(OUT_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] data,
  input  logic [2:0]        rate_code,
  input  logic              uncoded,
  output logic [OUT_W-1:0]  bits_o,
  output logic [CNT_W-1:0]  nbits_o,
  output logic [K-2:0]      hist_o
);

  logic [K-2:0]           hist_q;
  logic [PH_W-1:0]        ph_q;
  rate_e                  rate_q;

  rate_e                  r_new;
  logic [PH_W-1:0]        per;
  logic [PUNCT_MAX-1:0]   kx, ky;
  logic [K-2:0]           st;
  logic [PH_W-1:0]        ph;
  logic [K-1:0]           win;
  logic                   xb, yb;
  logic [OUT_W-1:0]       acc;
  logic [CNT_W-1:0]       cnt;

  // Whole byte encoded in one pass: history and puncture position ripple
  // through DATA_W unrolled steps.
  always_comb begin
    r_new = rate_decode(rate_code);
    per   = punct_period(r_new);
    kx    = keep_x(r_new);
    ky    = keep_y(r_new);
    ph    = (r_new != rate_q) ? '0 : ph_q;
    st    = hist_q;
    win   = '0;
    xb    = 1'b0;
    yb    = 1'b0;
    acc   = '0;
    cnt   = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (uncoded) begin
        acc = {acc[OUT_W-2:0], data[i]};
        cnt = cnt + 1'b1;
      end else begin
        win = {data[i], st};
        xb  = ^(win & GEN_X);
        yb  = ^(win & GEN_Y);
        if (kx[ph]) begin
          acc = {acc[OUT_W-2:0], xb};
          cnt = cnt + 1'b1;
        end
        if (ky[ph]) begin
          acc = {acc[OUT_W-2:0], yb};
          cnt = cnt + 1'b1;
        end
        st = win[K-1:1];
        ph = (ph == per - 1'b1) ? '0 : ph + 1'b1;
      end
    end
    bits_o  = acc << (OUT_W - int'(cnt));
    nbits_o = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      ph_q   <= '0;
      rate_q <= RATE_1_2;
    end else if (take && !uncoded) begin
      hist_q <= st;
      ph_q   <= ph;
      rate_q <= r_new;
    end
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/cps_pair_buffer.sv
module cps_pair_buffer #(
  parameter int  IN_W   = 16,
  parameter int  BUF_W  = IN_W + 2,
  parameter int  REQ_TH = 4,
  localparam int CNT_W  = $clog2(IN_W + 1),
  localparam int LVL_W  = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_bits,
  input  logic [CNT_W-1:0] in_cnt,
  output logic             byte_req_o,
  output logic             i_bit_o,
  output logic             q_bit_o,
  output logic [LVL_W-1:0] level_o
);

  logic [BUF_W-1:0] sh_q, sh_d, ins;
  logic [LVL_W-1:0] lvl_q, lvl_c, lvl_d;
  logic             drain;
  logic             req_q;

  always_comb begin
    drain = (lvl_q >= LVL_W'(2));
    lvl_c = drain ? (lvl_q - LVL_W'(2)) : lvl_q;
    ins   = (BUF_W'(in_bits) << (BUF_W - IN_W)) >> lvl_c;
    sh_d  = (drain ? (sh_q << 2) : sh_q) | (req_q ? ins : '0);
    lvl_d = lvl_c + (req_q ? LVL_W'(in_cnt) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      lvl_q <= '0;
      req_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      lvl_q <= lvl_d;
      req_q <= (lvl_d < LVL_W'(REQ_TH));
    end
  end

  assign byte_req_o = req_q;
  assign i_bit_o    = sh_q[BUF_W-1];
  assign q_bit_o    = sh_q[BUF_W-2];
  assign level_o    = lvl_q;

endmodule

// File: rtl/conv_punct_ser.sv
module conv_punct_ser #(
  parameter int           DATA_W = 8,
  parameter int           K      = 7,
  parameter logic [K-1:0] GEN_X  = 7'o171,
  parameter logic [K-1:0] GEN_Y  = 7'o133
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic [2:0]        rate_sel,
  input  logic              uncoded_en,
  output logic              byte_req,
  output logic              i_bit,
  output logic              q_bit
);

  localparam int IN_W   = 2 * DATA_W;
  localparam int CNT_W  = $clog2(IN_W + 1);
  localparam int BUF_W  = IN_W + 2;
  localparam int REQ_TH = 4;
  localparam int LVL_W  = $clog2(BUF_W + 1);

  logic [IN_W-1:0]  enc_bits;
  logic [CNT_W-1:0] enc_cnt;
  logic [K-2:0]     hist;
  logic [LVL_W-1:0] level;

  cps_conv_coder #(
    .DATA_W (DATA_W),
    .K      (K),
    .GEN_X  (GEN_X),
    .GEN_Y  (GEN_Y)
  ) u_coder (
    .clk       (clk),
    .rst       (rst),
    .take      (byte_req),
    .data      (data_in),
    .rate_code (rate_sel),
    .uncoded   (uncoded_en),
    .bits_o    (enc_bits),
    .nbits_o   (enc_cnt),
    .hist_o    (hist)
  );

  cps_pair_buffer #(
    .IN_W   (IN_W),
    .BUF_W  (BUF_W),
    .REQ_TH (REQ_TH)
  ) u_buf (
    .clk        (clk),
    .rst        (rst),
    .in_bits    (enc_bits),
    .in_cnt     (enc_cnt),
    .byte_req_o (byte_req),
    .i_bit_o    (i_bit),
    .q_bit_o    (q_bit),
    .level_o    (level)
  );

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int BUF_W = 18,
  parameter int LVL_W = 5,
  parameter int K     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_req,
  input logic             i_bit,
  input logic             q_bit,
  input logic             uncoded_en,
  input logic [LVL_W-1:0] level,
  input logic [K-2:0]     hist
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (byte_req && !i_bit && !q_bit && hist == '0)); // R1

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    (level >= LVL_W'(2)) |=> (level >= LVL_W'(2))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(BUF_W)); // R6

  AST_BYTE_FILLS: assert property (@(posedge clk) disable iff (rst)
    byte_req |=> (level >= LVL_W'(8))); // R7

  AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (rst)
    !byte_req |=> (level == $past(level) - LVL_W'(2))); // R7

  AST_UNCODED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (byte_req && uncoded_en) |=> $stable(hist)); // R5

endmodule

bind conv_punct_ser cps_checker #(
  .BUF_W (BUF_W),
  .LVL_W (LVL_W),
  .K     (K)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_req   (byte_req),
  .i_bit      (i_bit),
  .q_bit      (q_bit),
  .uncoded_en (uncoded_en),
  .level      (level),
  .hist       (hist)
);

// File: tb/conv_punct_ser_bench.sv
module conv_punct_ser_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = '0;
  logic [2:0] rate_sel = '0;
  logic       uncoded_en = 1'b0;
  wire        byte_req, i_bit, q_bit;

  always #5 clk = ~clk;

  conv_punct_ser u_conv_punct_ser (
    .clk        (clk),
    .rst        (rst),
    .data_in    (data_in),
    .rate_sel   (rate_sel),
    .uncoded_en (uncoded_en),
    .byte_req   (byte_req),
    .i_bit      (i_bit),
    .q_bit      (q_bit)
  );

  typedef struct packed {
    logic [2:0] code;
    logic       unc;
    logic [7:0] nbytes;
    logic [4:0] first_bits;
  } seg_t;

  localparam int NSEG = 12;
  // code, uncoded, bytes, bits emitted by the segment's first byte (phase 0)
  localparam seg_t TBL [NSEG] = '{
    '{3'd0, 1'b0, 8'd10, 5'd16},
    '{3'd1, 1'b0, 8'd10, 5'd12},
    '{3'd2, 1'b0, 8'd11, 5'd11},
    '{3'd3, 1'b0, 8'd11, 5'd10},
    '{3'd4, 1'b0, 8'd15, 5'd10},
    '{3'd6, 1'b0, 8'd8,  5'd16},
    '{3'd5, 1'b1, 8'd6,  5'd8},
    '{3'd2, 1'b0, 8'd9,  5'd11},
    '{3'd7, 1'b0, 8'd8,  5'd16},
    '{3'd3, 1'b0, 8'd10, 5'd10},
    '{3'd4, 1'b0, 8'd9,  5'd10},
    '{3'd1, 1'b0, 8'd8,  5'd12}
  };

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;

  // model state
  logic [5:0] m_st;
  int         m_ph;
  int         m_rate;
  bit         expq [0:255];
  string      expt [0:255];
  int         qh, qt;
  bit         started;

  // stimulus state
  int         mode;
  logic [2:0] seg_code;
  logic       seg_unc;
  int         seg_left;
  bit         seg_first;
  int         seg_fb;
  logic [7:0] f_d [3];
  logic [2:0] f_c [3];
  logic       f_u [3];
  int         f_idx;
  logic [7:0] lf = 8'h5A;
  logic [15:0] junk = 16'hACE1;

  bit          cap_on;
  int          cap_n;
  logic [39:0] cap;

  function automatic int per_of(input int r);
    case (r) 1: return 2; 2: return 3; 3: return 5; 4: return 7; default: return 1; endcase
  endfunction
  function automatic logic [6:0] xm_of(input int r);
    case (r) 1: return 7'b0000001; 2: return 7'b0000101; 3: return 7'b0010101;
      4: return 7'b1010001; default: return 7'b0000001; endcase
  endfunction
  function automatic logic [6:0] ym_of(input int r);
    case (r) 1: return 7'b0000011; 2: return 7'b0000011; 3: return 7'b0001011;
      4: return 7'b0101111; default: return 7'b0000001; endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic qpush(input bit b, input string tag);
    expq[qt & 255] = b;
    expt[qt & 255] = tag;
    qt++;
  endtask

  task automatic push_byte(input logic [7:0] d, input logic [2:0] code,
                           input logic unc, output int n);
    int dec;
    string tag;
    logic [6:0] w;
    logic x, y;
    n = 0;
    dec = (code > 3'd4) ? 0 : int'(code);
    tag = unc ? "R5" : (code > 3'd4) ? "R4" : (dec == 0) ? "R2" : "R3";
    if (unc) begin
      for (int i = 7; i >= 0; i--) begin qpush(d[i], tag); n++; end
    end else begin
      if (dec != m_rate) m_ph = 0;   // R8 restart
      m_rate = dec;
      for (int i = 7; i >= 0; i--) begin
        w = {d[i], m_st};
        x = w[6] ^ w[5] ^ w[4] ^ w[3] ^ w[0];
        y = w[6] ^ w[4] ^ w[3] ^ w[1] ^ w[0];
        if (xm_of(dec)[m_ph]) begin qpush(x, tag); n++; end
        if (ym_of(dec)[m_ph]) begin qpush(y, tag); n++; end
        m_st = w[6:1];
        m_ph = (m_ph == per_of(dec) - 1) ? 0 : m_ph + 1;
      end
    end
  endtask

  task automatic supply();
    logic [7:0] d;
    logic [2:0] c;
    logic       u;
    int         n;
    if (mode == 0 && seg_left > 0) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      d = lf; c = seg_code; u = seg_unc;
    end else if (mode == 1 && f_idx < 3) begin
      d = f_d[f_idx]; c = f_c[f_idx]; u = f_u[f_idx]; f_idx++;
    end else begin
      d = 8'h00; c = 3'd0; u = 1'b0;
    end
    data_in = d; rate_sel = c; uncoded_en = u;
    push_byte(d, c, u, n);
    if (mode == 0 && seg_left > 0) begin
      if (seg_first) check(n == seg_fb, "R8", "bits from first byte of segment", n, seg_fb);
      seg_first = 1'b0;
      seg_left--;
    end
  endtask

  task automatic step();
    if (!started) begin
      check(i_bit == 1'b0 && q_bit == 1'b0, "R1", "first pair after reset", {i_bit, q_bit}, 0);
      check(byte_req == 1'b1, "R1", "byte_req after reset", byte_req, 1);
      started = 1'b1;
    end else if (qt - qh < 2) begin
      check(1'b0, "R6", "symbol gap, queued bits", qt - qh, 2);
    end else begin
      check(i_bit == expq[qh & 255], expt[qh & 255], "i_bit", i_bit, expq[qh & 255]);
      check(q_bit == expq[(qh + 1) & 255], expt[(qh + 1) & 255], "q_bit", q_bit,
            expq[(qh + 1) & 255]);
      if (cap_on && cap_n < 40) begin cap = {cap[37:0], i_bit, q_bit}; cap_n += 2; end
      qh += 2;
    end
    if (byte_req) supply();
    else begin
      // R7: junk on every sampled input while no byte is requested
      junk = {junk[14:0], junk[15] ^ junk[13] ^ junk[12] ^ junk[10]};
      data_in = junk[7:0]; rate_sel = junk[10:8]; uncoded_en = junk[11];
    end
    check(qt - qh <= 18, "R6", "buffered bits above bound", qt - qh, 18);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(byte_req == 1'b1 && i_bit == 1'b0 && q_bit == 1'b0, "R1", "state during reset",
          {byte_req, i_bit, q_bit}, 4);
    rst = 1'b0;
    m_st = '0; m_ph = 0; m_rate = 0; qh = 0; qt = 0; started = 1'b0;
    step();
  endtask

  initial begin
    cap_on = 1'b0; cap_n = 0; cap = '0; f_idx = 3; mode = 0; seg_left = 0;
    do_reset();
    // vector table walk
    for (int s = 0; s < NSEG; s++) begin
      seg_code = TBL[s].code; seg_unc = TBL[s].unc;
      seg_left = int'(TBL[s].nbytes); seg_fb = int'(TBL[s].first_bits); seg_first = 1'b1;
      while (seg_left > 0) begin @(negedge clk); step(); end
    end
    mode = 2;
    repeat (20) begin @(negedge clk); step(); end
    // directed: impulse at LSB, uncoded byte in between, then zeros
    f_d[0] = 8'h01; f_c[0] = 3'd0; f_u[0] = 1'b0;
    f_d[1] = 8'hFF; f_c[1] = 3'd3; f_u[1] = 1'b1;
    f_d[2] = 8'h00; f_c[2] = 3'd0; f_u[2] = 1'b0;
    f_idx = 0; mode = 1; cap_on = 1'b1; cap_n = 0;
    do_reset();
    repeat (24) begin @(negedge clk); step(); end
    // R2 generators, R5 history hold, R7 junk ignored, R9 MSB first
    check(cap == 40'h0003_FF_BC70, "R9", "directed impulse stream (R2 R5 R7)",
          int'(cap[31:0]), 32'h03FF_BC70);
    // reset during heavy traffic, then short run at rate 7/8
    mode = 0; seg_code = 3'd4; seg_unc = 1'b0; seg_left = 6; seg_fb = 10; seg_first = 1'b1;
    do_reset();
    while (seg_left > 0) begin @(negedge clk); step(); end
    mode = 2;
    repeat (12) begin @(negedge clk); step(); end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule